// File: doc/BRIEF.md
# Inter-Transaction Bus Turnaround Controller

This block sits in front of a static-memory port and decides how many idle controller clock cycles must pass between the end of one transaction and the start of the next. When a transaction finishes, its done pulse carries a short descriptor. The descriptor says whether the transfer was synchronous, whether it was a write, which bank it used, and whether that bank runs address/data multiplexed or in the fourth asynchronous access style ("mode D"). The block stores this descriptor.

A pending transaction raises a request with its own descriptor: synchronous or not, write or not, and target bank. The block compares the two descriptors. It then demands one of three gaps: none, the software-programmed turnaround count, or a fixed gap of two or three cycles. Idle cycles count from the cycle after the done pulse. Grant rises once enough of them have passed.

Idle cycles that elapse before the request arrives count toward the gap. A gap of zero grants in the same cycle as the request.

Top module: `tat_ctrl`

## Requirements
- R1: After an asynchronous write (done_sync=0, done_write=1), the next request waits `turn_cycles` idle cycles (0 to 15). This applies when that request is a read, is synchronous, or targets a different bank.
- R2: After an asynchronous write, an asynchronous write to the same bank (req_bank equal to the stored bank) waits zero cycles. This holds when the stored descriptor has neither the multiplexed flag nor the mode D flag set.
- R3: After an asynchronous write whose stored descriptor has the multiplexed or mode D flag set, an asynchronous write to the same bank waits `turn_cycles` cycles.
- R4: After a synchronous write (done_sync=1, done_write=1), a synchronous write to the same bank waits exactly 2 cycles, whatever `turn_cycles` holds.
- R5: After a synchronous write, any asynchronous request (req_sync=0), read or write, waits exactly 2 cycles.
- R6: After a synchronous write, a synchronous write to a different bank waits exactly 3 cycles.
- R7: After a synchronous write, a synchronous read (req_write=0) from any bank waits exactly 3 cycles.
- R8: After a read (done_write=0), synchronous or asynchronous, the next request waits zero cycles.
- R9: Reset clears the stored descriptor, including in the middle of a gap, so the first request after reset is granted in the cycle it appears.
- R10: `grant` is high only while `req` is high and `done` is low.
- R11: With a gap of N, a request is granted in the cycle N+1 cycles after the done cycle, or at once if it arrives later. Each new done pulse restarts the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| turn_cycles | input | CNT_W (4) | Programmed turnaround count |
| done | input | 1 | One-cycle pulse: current transaction completed |
| done_sync | input | 1 | Completed transaction was synchronous |
| done_write | input | 1 | Completed transaction was a write |
| done_bank | input | 2 | Bank of the completed transaction |
| done_muxed | input | 1 | Completed bank runs address/data multiplexed |
| done_mode_d | input | 1 | Completed bank runs mode D |
| req | input | 1 | Pending transaction requests the bus |
| req_sync | input | 1 | Pending transaction is synchronous |
| req_write | input | 1 | Pending transaction is a write |
| req_bank | input | 2 | Bank of the pending transaction |
| grant | output | 1 | Pending transaction may start |

## Verification
The properties take for granted three things about the inputs:
- `done` is a single-cycle pulse.
- The request descriptor stays stable while `req` waits.
- The programmed count does not change between a done pulse and its grant.

The cycle-after-done properties also assume the pending request is already present in that cycle. The stimulus keeps within these limits in three ways. It drives every input half a cycle away from the sampling edge. It raises `req` exactly one cycle after the done pulse, except in the directed cases that test late requests. It holds `turn_cycles` fixed for the whole gap it measures.

// File: rtl/tat_pkg.sv
package tat_pkg;
  localparam int unsigned TAT_BANK_W = 2;

  typedef struct packed {
    logic                  sync;
    logic                  write;
    logic                  muxed;
    logic                  mode_d;
    logic [TAT_BANK_W-1:0] bank;
  } tat_xact_t;
endpackage

// File: rtl/tat_desc_reg.sv
module tat_desc_reg
  import tat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  tat_xact_t d,
  output tat_xact_t q,
  output logic      valid
);
  tat_xact_t q_nxt;
  logic      valid_nxt;

  always_comb begin
    q_nxt     = q;
    valid_nxt = valid;
    if (capture) begin
      q_nxt     = d;
      valid_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (capture) begin
      q     <= q_nxt;
      valid <= valid_nxt;
    end
  end
endmodule

// File: rtl/tat_gap_rule.sv
module tat_gap_rule
  import tat_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned FIX_NEAR = 2,
  parameter int unsigned FIX_FAR  = 3
) (
  input  tat_xact_t              prev,
  input  logic                   prev_valid,
  input  logic                   nxt_sync,
  input  logic                   nxt_write,
  input  logic [TAT_BANK_W-1:0]  nxt_bank,
  input  logic [CNT_W-1:0]       cfg,
  output logic [CNT_W-1:0]       need
);
  localparam logic [CNT_W-1:0] NEAR = CNT_W'(FIX_NEAR);
  localparam logic [CNT_W-1:0] FAR  = CNT_W'(FIX_FAR);

  logic same_bank;
  logic plain_bank;

  assign same_bank  = (prev.bank == nxt_bank);
  assign plain_bank = !prev.muxed && !prev.mode_d;

  always_comb begin
    if (!prev_valid || !prev.write) begin
      need = '0;
    end else if (prev.sync) begin
      if (!nxt_sync)                   need = NEAR;
      else if (nxt_write && same_bank) need = NEAR;
      else                             need = FAR;
    end else begin
      if (!nxt_sync && nxt_write && same_bank && plain_bank) need = '0;
      else                                                   need = cfg;
    end
  end
endmodule

// File: rtl/tat_idle_cnt.sv
module tat_idle_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count_nxt;
  logic             count_en;

  always_comb begin
    count_en  = restart || (count != TOP);
    count_nxt = restart ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_nxt;
  end
endmodule

// File: rtl/tat_ctrl.sv
module tat_ctrl
  import tat_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned FIX_NEAR = 2,
  parameter int unsigned FIX_FAR  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      turn_cycles,
  input  logic                  done,
  input  logic                  done_sync,
  input  logic                  done_write,
  input  logic [TAT_BANK_W-1:0] done_bank,
  input  logic                  done_muxed,
  input  logic                  done_mode_d,
  input  logic                  req,
  input  logic                  req_sync,
  input  logic                  req_write,
  input  logic [TAT_BANK_W-1:0] req_bank,
  output logic                  grant
);
  tat_xact_t        fin_desc;
  tat_xact_t        last_desc;
  logic             last_valid;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] idle;

  always_comb begin
    fin_desc.sync   = done_sync;
    fin_desc.write  = done_write;
    fin_desc.muxed  = done_muxed;
    fin_desc.mode_d = done_mode_d;
    fin_desc.bank   = done_bank;
  end

  tat_desc_reg u_last (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (done),
    .d       (fin_desc),
    .q       (last_desc),
    .valid   (last_valid)
  );

  tat_gap_rule #(
    .CNT_W    (CNT_W),
    .FIX_NEAR (FIX_NEAR),
    .FIX_FAR  (FIX_FAR)
  ) u_rule (
    .prev       (last_desc),
    .prev_valid (last_valid),
    .nxt_sync   (req_sync),
    .nxt_write  (req_write),
    .nxt_bank   (req_bank),
    .cfg        (turn_cycles),
    .need       (need)
  );

  tat_idle_cnt #(.CNT_W(CNT_W)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (done),
    .count   (idle)
  );

  assign grant = req && !done && (idle >= need);
endmodule

// File: rtl/tat_ctrl_chk.sv
module tat_ctrl_chk
  import tat_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CNT_W-1:0]      turn_cycles,
  input logic                  done,
  input logic                  done_sync,
  input logic                  done_write,
  input logic [TAT_BANK_W-1:0] done_bank,
  input logic                  done_muxed,
  input logic                  done_mode_d,
  input logic                  req,
  input logic                  req_sync,
  input logic                  req_write,
  input logic [TAT_BANK_W-1:0] req_bank,
  input logic                  grant
);
  // R10
  grant_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (req && !done));

  // R8
  read_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && !$past(done_write) && req && !done) |-> grant);

  // R2
  async_pair_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && $past(done_write) && !$past(done_sync) &&
     !$past(done_muxed) && !$past(done_mode_d) &&
     req && !done && req_write && !req_sync &&
     (req_bank == $past(done_bank))) |-> grant);

  // R4 (also R5, R6, R7: every gap after a synchronous write is at least two)
  sync_write_min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && $past(done_write) && $past(done_sync) && req) |-> !grant);

  // R1
  async_write_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && $past(done_write) && !$past(done_sync) &&
     (turn_cycles != '0) && req &&
     (req_sync || !req_write || (req_bank != $past(done_bank)) ||
      $past(done_muxed) || $past(done_mode_d))) |-> !grant);
endmodule

bind tat_ctrl tat_ctrl_chk #(.CNT_W(CNT_W)) u_tat_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .turn_cycles (turn_cycles),
  .done        (done),
  .done_sync   (done_sync),
  .done_write  (done_write),
  .done_bank   (done_bank),
  .done_muxed  (done_muxed),
  .done_mode_d (done_mode_d),
  .req         (req),
  .req_sync    (req_sync),
  .req_write   (req_write),
  .req_bank    (req_bank),
  .grant       (grant)
);

// File: tb/tat_ctrl_test.sv
`timescale 1ns/1ps
module tat_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] turn_cycles;
  logic       done, done_sync, done_write, done_muxed, done_mode_d;
  logic [1:0] done_bank;
  logic       req, req_sync, req_write;
  logic [1:0] req_bank;
  logic       grant;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  tat_ctrl uut (
    .clk(clk), .rst_n(rst_n), .turn_cycles(turn_cycles),
    .done(done), .done_sync(done_sync), .done_write(done_write),
    .done_bank(done_bank), .done_muxed(done_muxed), .done_mode_d(done_mode_d),
    .req(req), .req_sync(req_sync), .req_write(req_write), .req_bank(req_bank),
    .grant(grant)
  );

  // {p_sync, p_write, p_bank[1:0], p_mux, p_md, n_sync, n_write, n_bank[1:0], cfg[3:0], gap[3:0]}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,1'b1,2'd1,1'b0,1'b0, 1'b0,1'b1,2'd1, 4'd7,  4'd0},
    {1'b0,1'b1,2'd1,1'b1,1'b0, 1'b0,1'b1,2'd1, 4'd7,  4'd7},
    {1'b0,1'b1,2'd1,1'b0,1'b1, 1'b0,1'b1,2'd1, 4'd5,  4'd5},
    {1'b0,1'b1,2'd1,1'b0,1'b0, 1'b0,1'b1,2'd2, 4'd4,  4'd4},
    {1'b0,1'b1,2'd0,1'b0,1'b0, 1'b0,1'b0,2'd0, 4'd6,  4'd6},
    {1'b0,1'b1,2'd0,1'b0,1'b0, 1'b1,1'b1,2'd0, 4'd15, 4'd15},
    {1'b0,1'b1,2'd2,1'b0,1'b0, 1'b1,1'b0,2'd3, 4'd0,  4'd0},
    {1'b1,1'b1,2'd1,1'b0,1'b0, 1'b1,1'b1,2'd1, 4'd9,  4'd2},
    {1'b1,1'b1,2'd1,1'b0,1'b0, 1'b0,1'b1,2'd1, 4'd9,  4'd2},
    {1'b1,1'b1,2'd0,1'b0,1'b0, 1'b0,1'b0,2'd3, 4'd0,  4'd2},
    {1'b1,1'b1,2'd0,1'b0,1'b0, 1'b1,1'b1,2'd2, 4'd9,  4'd3},
    {1'b1,1'b1,2'd2,1'b0,1'b0, 1'b1,1'b0,2'd2, 4'd1,  4'd3},
    {1'b1,1'b1,2'd3,1'b0,1'b0, 1'b1,1'b0,2'd0, 4'd9,  4'd3},
    {1'b0,1'b0,2'd0,1'b0,1'b0, 1'b0,1'b1,2'd0, 4'd9,  4'd0},
    {1'b1,1'b0,2'd1,1'b0,1'b0, 1'b1,1'b1,2'd2, 4'd9,  4'd0}
  };
  string tags [NV];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic idle_bus();
    done = 0; done_sync = 0; done_write = 0; done_bank = 0;
    done_muxed = 0; done_mode_d = 0;
    req = 0; req_sync = 0; req_write = 0; req_bank = 0;
  endtask

  task automatic pulse_done(input logic s, input logic w, input logic [1:0] b,
                            input logic m, input logic d);
    @(negedge clk);
    done = 1; done_sync = s; done_write = w; done_bank = b;
    done_muxed = m; done_mode_d = d;
    @(negedge clk);
    done = 0;
  endtask

  // raises req at the current negedge, returns cycles waited until grant
  task automatic wait_grant(input logic s, input logic w, input logic [1:0] b,
                            output int waited);
    req = 1; req_sync = s; req_write = w; req_bank = b;
    #1;
    waited = 0;
    while (!grant && waited < 40) begin
      @(negedge clk); #1;
      waited++;
    end
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    int w;
    tags[0] = "R2";  tags[1] = "R3";  tags[2] = "R3";  tags[3] = "R1";
    tags[4] = "R1";  tags[5] = "R1";  tags[6] = "R1";  tags[7] = "R4";
    tags[8] = "R5";  tags[9] = "R5";  tags[10] = "R6"; tags[11] = "R7";
    tags[12] = "R7"; tags[13] = "R8"; tags[14] = "R8";
    rst_n = 0; turn_cycles = 4'd15;
    idle_bus();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset state, first request sees no gap; R10: no grant without req
    #1 check(grant == 1'b0, "R10 idle grant", grant, 0);
    @(negedge clk);
    wait_grant(1'b1, 1'b0, 2'd0, w);
    check(w == 0, "R9 first request", w, 0);

    // main table
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      turn_cycles = v[7:4];
      pulse_done(v[17], v[16], v[15:14], v[13], v[12]);
      wait_grant(v[11], v[10], v[9:8], w);
      check(w == int'(v[3:0]), tags[i], w, int'(v[3:0]));
    end

    // R11: idle cycles before the request count toward the gap
    turn_cycles = 4'd15;
    pulse_done(1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    wait_grant(1'b1, 1'b1, 2'd3, w);
    check(w == 0, "R11 late request", w, 0);

    // R11: request arriving partway through the gap
    turn_cycles = 4'd6;
    pulse_done(1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    wait_grant(1'b0, 1'b0, 2'd0, w);
    check(w == 4, "R11 partial gap", w, 4);

    // R11: a second done pulse restarts the count
    turn_cycles = 4'd5;
    pulse_done(1'b0, 1'b1, 2'd1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    pulse_done(1'b0, 1'b1, 2'd1, 1'b0, 1'b0);
    wait_grant(1'b1, 1'b1, 2'd1, w);
    check(w == 5, "R11 restart", w, 5);

    // R10: grant masked during the done cycle even with zero gap
    pulse_done(1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    done = 1; done_write = 0; req = 1; req_write = 0;
    #1 check(grant == 1'b0, "R10 done cycle", grant, 0);
    @(negedge clk);
    done = 0;
    #1 check(grant == 1'b1, "R10 after done", grant, 1);
    @(negedge clk);
    req = 0;

    // R9: reset in the middle of a gap
    turn_cycles = 4'd15;
    pulse_done(1'b0, 1'b1, 2'd2, 1'b0, 1'b0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    wait_grant(1'b1, 1'b0, 2'd2, w);
    check(w == 0, "R9 reset mid gap", w, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule